// File: doc/BRIEF.md
# Self-Indexing ROM Checksum Verifier

This block walks through a bank of program ROMs over a plain synchronous read port and checks each one with an 8-bit additive checksum. Each ROM image holds one compensating byte, chosen so that the modulo-256 sum of all of its bytes equals the number of the socket it is meant to sit in. A single comparison per ROM therefore catches two faults. It catches corrupted contents. It also catches a good image that was fitted into the wrong socket. No table of reference sums is needed.

A scan starts with a one-cycle start request while the block is idle. The verifier then issues one read per cycle. It goes through socket 1 up to the last socket, and through byte addresses 0 upward inside each socket. It records the first socket whose sum is wrong, together with the sum it found there. If that sum equals the number of some other socket, the verifier reports that socket as a likely swap partner. A mode input, sampled when the scan is accepted, selects one of two behaviours at the first mismatch: stop at once, or go on to the end of the bank.

Top module: `rom_sum_verifier`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, pass_o, rd_en_o and swap_o are 0, and fail_idx_o, fail_sum_o and swap_idx_o are 0.
- R2: After a start is accepted, rd_en_o is high for one read per cycle. rd_rom_o steps from 1 to NUM_ROMS, and inside each socket rd_addr_o steps from 0 to ROM_BYTES-1. The read data is taken on rd_data_i one clock after the address is presented.
- R3: Socket n is good exactly when the modulo-256 sum of all ROM_BYTES bytes read from it equals n.
- R4: In run-to-end mode, done_o rises and busy_o falls at the clock edge NUM_ROMS*ROM_BYTES+1 edges after the edge that accepted start. done_o then stays high until the next accepted start.
- R5: pass_o is 1 after a scan exactly when every socket was good, and 0 otherwise.
- R6: fail_idx_o holds the lowest failing socket number and fail_sum_o holds the sum read from that socket. A later failing socket does not change them. Both are 0 when no socket failed.
- R7: swap_o is 1 and swap_idx_o equals k when the first failing sum is a value k with 1 <= k <= NUM_ROMS. Otherwise swap_o and swap_idx_o are 0.
- R8: With stop_on_fail_i = 1 at the accepted start, a first failure at socket k ends the scan, with done_o high and busy_o low, k*ROM_BYTES+1 edges after the accepting edge. Exactly k*ROM_BYTES+1 read strobes are issued when k < NUM_ROMS, and NUM_ROMS*ROM_BYTES when k = NUM_ROMS.
- R9: A start request or a change of stop_on_fail_i while busy_o is high has no effect on the running scan, its timing or its results.
- R10: An accepted start clears done_o and all failure and swap results from the previous scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Scan request, accepted only while idle |
| stop_on_fail_i | input | 1 | 1: stop at first mismatch; 0: scan the whole bank |
| rd_en_o | output | 1 | Read strobe for the current socket and address |
| rd_rom_o | output | IDXW | Socket number being read, 1-based |
| rd_addr_o | output | AW | Byte address inside the socket |
| rd_data_i | input | 8 | Read data, valid one clock after the address |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished, results valid |
| pass_o | output | 1 | All sockets matched their own number |
| fail_idx_o | output | IDXW | First failing socket, 0 if none |
| fail_sum_o | output | 8 | Sum found in the first failing socket |
| swap_o | output | 1 | First failing sum names another socket |
| swap_idx_o | output | IDXW | That socket number, 0 if none |

## Verification
The hardest case to reach is a stop-mode abort. At the moment the failing socket's final byte is compared, the first read of the next socket is already in flight. That read must be discarded, and done must land on the exact edge. The bench builds each image by placing a compensating byte at a random position, so that the image sums to a chosen value. This lets it put a failure on a chosen socket, including the last one, and make the failing sum hit another socket's number, zero, or an out-of-range value. Further scans pulse start and flip the mode in the middle of a run, to show that both are ignored while busy.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int SUM_W = 8;

  typedef logic [SUM_W-1:0] sum_t;

  typedef enum logic [1:0] {
    SCAN_IDLE  = 2'd0,
    SCAN_RUN   = 2'd1,
    SCAN_DRAIN = 2'd2
  } scan_st_e;
endpackage

// File: rtl/rsv_fetch.sv
module rsv_fetch
  import rsv_pkg::*;
#(
  parameter int NUM_ROMS  = 26,
  parameter int ROM_BYTES = 1024,
  parameter int IDXW      = 5,
  parameter int AW        = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic            abort_i,
  input  logic            finish_i,
  output logic            rd_en_o,
  output logic [IDXW-1:0] rd_rom_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic            byte_last_o,
  output logic            busy_o
);
  localparam logic [AW-1:0]   LAST_ADDR = AW'(ROM_BYTES - 1);
  localparam logic [IDXW-1:0] LAST_ROM  = IDXW'(NUM_ROMS);

  scan_st_e        st_q, st_d;
  logic [IDXW-1:0] rom_q, rom_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic            en_q, en_d;
  logic            upd;

  assign byte_last_o = (addr_q == LAST_ADDR);
  assign upd         = go_i | abort_i | (st_q != SCAN_IDLE);

  always_comb begin
    st_d   = st_q;
    rom_d  = rom_q;
    addr_d = addr_q;
    en_d   = en_q;
    case (st_q)
      SCAN_IDLE: begin
        if (go_i) begin
          st_d   = SCAN_RUN;
          rom_d  = IDXW'(1);
          addr_d = '0;
          en_d   = 1'b1;
        end
      end
      SCAN_RUN: begin
        if (byte_last_o) begin
          addr_d = '0;
          if (rom_q == LAST_ROM) begin
            en_d = 1'b0;
            st_d = SCAN_DRAIN;
          end else begin
            rom_d = rom_q + IDXW'(1);
          end
        end else begin
          addr_d = addr_q + AW'(1);
        end
      end
      SCAN_DRAIN: begin
        if (finish_i) st_d = SCAN_IDLE;
      end
      default: st_d = SCAN_IDLE;
    endcase
    if (abort_i) begin
      st_d = SCAN_IDLE;
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCAN_IDLE;
      rom_q  <= '0;
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (upd) begin
      st_q   <= st_d;
      rom_q  <= rom_d;
      addr_q <= addr_d;
      en_q   <= en_d;
    end
  end

  assign rd_en_o   = en_q;
  assign rd_rom_o  = rom_q;
  assign rd_addr_o = addr_q;
  assign busy_o    = (st_q != SCAN_IDLE);

  // R2
  rom_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o) && rd_addr_o == '0) |-> rd_rom_o == $past(rd_rom_o) + IDXW'(1));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o) && rd_addr_o != '0) |-> rd_addr_o == $past(rd_addr_o) + AW'(1));
endmodule

// File: rtl/rsv_accum.sv
module rsv_accum
  import rsv_pkg::*;
#(
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic            iss_en_i,
  input  logic            iss_last_i,
  input  logic [IDXW-1:0] iss_rom_i,
  input  sum_t            rd_data_i,
  output logic            cmp_vld_o,
  output logic [IDXW-1:0] cmp_rom_o,
  output sum_t            cmp_sum_o
);
  logic            s_vld_q, s_vld_d;
  logic            s_last_q;
  logic [IDXW-1:0] s_rom_q;
  sum_t            acc_q, acc_d;
  sum_t            sum_now;

  assign sum_now = acc_q + rd_data_i;

  always_comb begin
    s_vld_d = flush_i ? 1'b0 : iss_en_i;
    acc_d   = acc_q;
    if (flush_i)      acc_d = '0;
    else if (s_vld_q) acc_d = s_last_q ? '0 : sum_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld_q  <= 1'b0;
      s_last_q <= 1'b0;
      s_rom_q  <= '0;
      acc_q    <= '0;
    end else begin
      s_vld_q  <= s_vld_d;
      s_last_q <= iss_last_i;
      s_rom_q  <= iss_rom_i;
      acc_q    <= acc_d;
    end
  end

  assign cmp_vld_o = s_vld_q & s_last_q;
  assign cmp_rom_o = s_rom_q;
  assign cmp_sum_o = sum_now;
endmodule

// File: rtl/rsv_verdict.sv
module rsv_verdict
  import rsv_pkg::*;
#(
  parameter int NUM_ROMS = 26,
  parameter int IDXW     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic            mode_i,
  input  logic            cmp_vld_i,
  input  logic [IDXW-1:0] cmp_rom_i,
  input  sum_t            cmp_sum_i,
  output logic            abort_o,
  output logic            finish_o,
  output logic            done_o,
  output logic            pass_o,
  output logic [IDXW-1:0] fail_idx_o,
  output sum_t            fail_sum_o,
  output logic            swap_o,
  output logic [IDXW-1:0] swap_idx_o
);
  localparam logic [8:0] TOP9 = 9'(NUM_ROMS);

  logic            mode_q, mode_d;
  logic            failed_q, failed_d;
  logic            done_q, done_d;
  logic [IDXW-1:0] fidx_q, fidx_d;
  sum_t            fsum_q, fsum_d;
  logic            swap_q, swap_d;
  logic [IDXW-1:0] sidx_q, sidx_d;
  logic [8:0]      sum9, rom9;
  logic            mismatch, hit;

  assign sum9     = {1'b0, cmp_sum_i};
  assign rom9     = 9'(cmp_rom_i);
  assign mismatch = cmp_vld_i && (sum9 != rom9);
  assign hit      = (sum9 != 9'd0) && (sum9 <= TOP9);
  assign abort_o  = mismatch && mode_q;
  assign finish_o = cmp_vld_i && (cmp_rom_i == IDXW'(NUM_ROMS));

  always_comb begin
    mode_d   = mode_q;
    failed_d = failed_q;
    done_d   = done_q;
    fidx_d   = fidx_q;
    fsum_d   = fsum_q;
    swap_d   = swap_q;
    sidx_d   = sidx_q;
    if (go_i) begin
      mode_d   = mode_i;
      failed_d = 1'b0;
      done_d   = 1'b0;
      fidx_d   = '0;
      fsum_d   = '0;
      swap_d   = 1'b0;
      sidx_d   = '0;
    end else begin
      if (mismatch && !failed_q) begin
        failed_d = 1'b1;
        fidx_d   = cmp_rom_i;
        fsum_d   = cmp_sum_i;
        swap_d   = hit;
        sidx_d   = hit ? cmp_sum_i[IDXW-1:0] : '0;
      end
      if (finish_o || abort_o) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      failed_q <= 1'b0;
      done_q   <= 1'b0;
      fidx_q   <= '0;
      fsum_q   <= '0;
      swap_q   <= 1'b0;
      sidx_q   <= '0;
    end else begin
      mode_q   <= mode_d;
      failed_q <= failed_d;
      done_q   <= done_d;
      fidx_q   <= fidx_d;
      fsum_q   <= fsum_d;
      swap_q   <= swap_d;
      sidx_q   <= sidx_d;
    end
  end

  assign done_o     = done_q;
  assign pass_o     = done_q & ~failed_q;
  assign fail_idx_o = fidx_q;
  assign fail_sum_o = fsum_q;
  assign swap_o     = swap_q;
  assign swap_idx_o = sidx_q;

  // R6
  first_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (failed_q && !go_i) |=> ($stable(fail_idx_o) && $stable(fail_sum_o)));

  // R7
  swap_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |-> (failed_q && swap_idx_o != fail_idx_o));
endmodule

// File: rtl/rom_sum_verifier.sv
module rom_sum_verifier
  import rsv_pkg::*;
#(
  parameter int  NUM_ROMS  = 26,
  parameter int  ROM_BYTES = 1024,
  localparam int IDXW      = $clog2(NUM_ROMS + 1),
  localparam int AW        = $clog2(ROM_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            stop_on_fail_i,
  output logic            rd_en_o,
  output logic [IDXW-1:0] rd_rom_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic [7:0]      rd_data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            pass_o,
  output logic [IDXW-1:0] fail_idx_o,
  output logic [7:0]      fail_sum_o,
  output logic            swap_o,
  output logic [IDXW-1:0] swap_idx_o
);
  logic            go, abort, finish, byte_last;
  logic            cmp_vld;
  logic [IDXW-1:0] cmp_rom;
  sum_t            cmp_sum;

  assign go = start_i & ~busy_o;

  rsv_fetch #(
    .NUM_ROMS (NUM_ROMS),
    .ROM_BYTES(ROM_BYTES),
    .IDXW     (IDXW),
    .AW       (AW)
  ) fetch_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go),
    .abort_i    (abort),
    .finish_i   (finish),
    .rd_en_o    (rd_en_o),
    .rd_rom_o   (rd_rom_o),
    .rd_addr_o  (rd_addr_o),
    .byte_last_o(byte_last),
    .busy_o     (busy_o)
  );

  rsv_accum #(
    .IDXW(IDXW)
  ) accum_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (go | abort),
    .iss_en_i  (rd_en_o),
    .iss_last_i(byte_last),
    .iss_rom_i (rd_rom_o),
    .rd_data_i (rd_data_i),
    .cmp_vld_o (cmp_vld),
    .cmp_rom_o (cmp_rom),
    .cmp_sum_o (cmp_sum)
  );

  rsv_verdict #(
    .NUM_ROMS(NUM_ROMS),
    .IDXW    (IDXW)
  ) verdict_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go),
    .mode_i    (stop_on_fail_i),
    .cmp_vld_i (cmp_vld),
    .cmp_rom_i (cmp_rom),
    .cmp_sum_i (cmp_sum),
    .abort_o   (abort),
    .finish_o  (finish),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_idx_o(fail_idx_o),
    .fail_sum_o(fail_sum_o),
    .swap_o    (swap_o),
    .swap_idx_o(swap_idx_o)
  );

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R8
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy_o && done_o && !rd_en_o));
endmodule

// File: tb/rom_sum_verifier_tb_top.sv
module rom_sum_verifier_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR   = 6;
  localparam int NB   = 16;
  localparam int IDXW = $clog2(NR + 1);
  localparam int AW   = $clog2(NB);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i, stop_on_fail_i;
  logic            rd_en_o;
  logic [IDXW-1:0] rd_rom_o;
  logic [AW-1:0]   rd_addr_o;
  logic [7:0]      rd_data_i;
  logic            busy_o, done_o, pass_o, swap_o;
  logic [IDXW-1:0] fail_idx_o, swap_idx_o;
  logic [7:0]      fail_sum_o;

  logic [7:0] mem [1:NR][0:NB-1];
  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int ord_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_sum_verifier #(.NUM_ROMS(NR), .ROM_BYTES(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_on_fail_i(stop_on_fail_i),
    .rd_en_o(rd_en_o), .rd_rom_o(rd_rom_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_idx_o(fail_idx_o),
    .fail_sum_o(fail_sum_o), .swap_o(swap_o), .swap_idx_o(swap_idx_o)
  );

  always @(posedge clk) begin
    if (int'(rd_rom_o) >= 1 && int'(rd_rom_o) <= NR) rd_data_i <= mem[rd_rom_o][rd_addr_o];
    else rd_data_i <= 8'h00;
  end

  always @(negedge clk) begin
    if (rd_en_o) begin
      if (int'(rd_rom_o) != rd_cnt / NB + 1 || int'(rd_addr_o) != rd_cnt % NB) ord_err++;
      rd_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic make_rom(input int s, input int target);
    int pos = int'($urandom % NB);
    int acc = 0;
    for (int i = 0; i < NB; i++) begin
      mem[s][i] = 8'($urandom);
      if (i != pos) acc += int'(mem[s][i]);
    end
    mem[s][pos] = 8'(target - acc);
  endtask

  function automatic int rom_sum(input int s);
    int acc = 0;
    for (int i = 0; i < NB; i++) acc += int'(mem[s][i]);
    return acc % 256;
  endfunction

  task automatic all_good();
    for (int s = 1; s <= NR; s++) make_rom(s, s);
  endtask

  task automatic run_scan(input bit mode, input int inj);
    int kf = 0, ks = 0, lat = 0, exp_lat, exp_rd, exp_sidx;
    bit exp_swap;
    for (int s = 1; s <= NR; s++)
      if (kf == 0 && rom_sum(s) != s) begin kf = s; ks = rom_sum(s); end
    exp_swap = (kf != 0) && ks >= 1 && ks <= NR;
    exp_sidx = exp_swap ? ks : 0;
    if (mode && kf != 0) begin
      exp_lat = kf * NB + 1;
      exp_rd  = (kf < NR) ? kf * NB + 1 : NR * NB;
    end else begin
      exp_lat = NR * NB + 1;
      exp_rd  = NR * NB;
    end
    @(negedge clk);
    rd_cnt = 0; ord_err = 0;
    start_i = 1'b1; stop_on_fail_i = mode;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && lat < 4 * NR * NB) begin
      if (inj > 0 && lat == inj) begin start_i = 1'b1; stop_on_fail_i = ~mode; end
      else begin start_i = 1'b0; stop_on_fail_i = mode; end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    start_i = 1'b0; stop_on_fail_i = mode;
    chk(lat == exp_lat, mode ? "R8" : "R4", "done latency", lat, exp_lat);
    chk(rd_cnt == exp_rd, mode ? "R8" : "R2", "read strobes", rd_cnt, exp_rd);
    chk(ord_err == 0, "R2", "read order errors", ord_err, 0);
    chk(!busy_o, "R4", "busy after done", int'(busy_o), 0);
    chk(pass_o == (kf == 0), "R5 R3", "pass", int'(pass_o), int'(kf == 0));
    chk(int'(fail_idx_o) == kf, "R6", "fail index", int'(fail_idx_o), kf);
    chk(int'(fail_sum_o) == ks, "R6", "fail sum", int'(fail_sum_o), ks);
    chk(swap_o == exp_swap, "R7", "swap flag", int'(swap_o), int'(exp_swap));
    chk(int'(swap_idx_o) == exp_sidx, "R7", "swap index", int'(swap_idx_o), exp_sidx);
    if (inj > 0) chk(lat == exp_lat && int'(fail_idx_o) == kf, "R9", "mid-scan start ignored", lat, exp_lat);
    @(negedge clk);
    chk(done_o == 1'b1, "R4", "done held", int'(done_o), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    rst_n = 1'b0; start_i = 1'b0; stop_on_fail_i = 1'b0;
    all_good();
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !pass_o && !rd_en_o && !swap_o, "R1", "flags in reset", 0, 0);
    chk(fail_idx_o == '0 && fail_sum_o == '0 && swap_idx_o == '0, "R1", "results in reset",
        int'(fail_sum_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !rd_en_o, "R1", "idle after release", int'(busy_o), 0);

    // R3 R4 R5: good bank, run to end
    run_scan(1'b0, 0);
    // R6: two bad sockets, first one recorded
    make_rom(3, 200); make_rom(5, 9);
    run_scan(1'b0, 0);
    // R10: good scan after a failing one clears results
    all_good();
    run_scan(1'b0, 0);
    // R7: socket 2 holds the image of socket 4
    make_rom(2, 4);
    run_scan(1'b0, 0);
    // R8: stop at socket 4, sum 0 (no swap)
    all_good(); make_rom(4, 0);
    run_scan(1'b1, 0);
    // R8: stop mode, nothing wrong
    all_good();
    run_scan(1'b1, 0);
    // R8: failure on the last socket in stop mode
    make_rom(NR, 250);
    run_scan(1'b1, 0);
    // R7 R9: out-of-range sum, start and mode flip mid-scan
    all_good(); make_rom(1, NR + 1);
    run_scan(1'b0, 20);
    // R9: mid-scan start in stop mode
    all_good(); make_rom(5, 3);
    run_scan(1'b1, 30);

    for (int r = 0; r < 20; r++) begin
      for (int s = 1; s <= NR; s++)
        make_rom(s, ($urandom % 4 == 0) ? int'($urandom % 256) : s);
      run_scan(1'($urandom), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule